// File: doc/BRIEF.md
# Dual Multi-Mode Timer Pair

This block holds two byte-pair timers that advance on a per-cycle tick strobe. Each timer has a low byte and a high byte. A 4-bit configuration field picks one of four counting modes, a gate bit, and a timer/counter select. A run bit in the control register starts each timer. When a timer wraps it raises its own sticky overflow flag, and the interrupt controller can clear that flag with a strobe.

Software reaches every register through a single write port and a combinational read port. The modes are a 13-bit count in which the low byte's low five bits act as a prescaler, a 16-bit cascade, an 8-bit count that reloads from the high byte, and a split mode for timer 0. In split mode the high byte of timer 0 becomes a separate 8-bit timer that is run by timer 1's run bit and reports through timer 1's flag. External-pin counting and pin gating are not built. A timer whose gate bit or counter select is set stays frozen.

Top module: `twin_tmr`

## Requirements
- R1: After reset every register reads 0, both `ovf` outputs are 0, and no timer runs.
- R2: A timer advances by one on a cycle with `tick` high only if its run bit is 1, its gate bit (config bit 3) is 0 and its counter select (config bit 2) is 0. In any other case it holds.
- R3: Mode 0 (config bits 1:0 = 00) counts only the low 5 bits of the low byte and leaves bits 7:5 unchanged. A carry out of those 5 bits increments the high byte. A wrap of the high byte from 0xFF sets the timer's flag.
- R4: Mode 1 (01) is a 16-bit count. A low-byte wrap increments the high byte, and a high-byte wrap sets the timer's flag.
- R5: Mode 2 (10) counts the low byte. When the low byte wraps from 0xFF, it loads the high byte's value and the flag is set.
- R6: Mode 3 (11) on timer 0 runs the low byte as an 8-bit timer under run bit 0, and its wrap sets flag 0. The high byte runs as an 8-bit timer under run bit 1, and its wrap sets flag 1.
- R7: While timer 0 is in mode 3, timer 1 may still count, but its own wraps do not set flag 1.
- R8: Timer 1 in mode 3 holds its bytes whatever its run bit says.
- R9: A register write in the same cycle as a count step wins. The written byte takes the written value.
- R10: A flag is cleared by writing 0 to its control bit or by a pulse on its `clr_ovf` line. An overflow in the same cycle as a clear strobe leaves the flag set.
- R11: Register map by `wr_addr`/`rd_addr`: 0 = configuration (timer 0 in bits 3:0, timer 1 in bits 7:4), 1 = control (run 0 bit 0, run 1 bit 1, flag 0 bit 4, flag 1 bit 5), 2/3 = timer 0 low/high, 4/5 = timer 1 low/high. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one step per high cycle |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| clr_ovf | input | 2 | Per-timer flag clear strobes |
| ovf | output | 2 | Per-timer overflow flags |

## Verification
Every counting byte can be read back on the port, so a wrong carry, reload or hold shows up in `rd_data` on the cycle after the tick that caused it. Flag routing faults are less direct. For example, timer 1's wrap may leak into flag 1 during split mode, or a clear strobe may win over a simultaneous overflow. These appear on `ovf` one edge after the event, and only when the bench lines up a wrap with that condition. The vectors therefore place wraps deliberately within a few ticks of loading a value near 0xFF.

// File: rtl/twin_tmr_pkg.sv
`timescale 1ns/1ps
package twin_tmr_pkg;
  parameter int unsigned TMR_W     = 8;
  parameter int unsigned TMR_PRE_W = 5;
  parameter int unsigned TMR_AW    = 3;
  localparam int unsigned CFG_W    = 4;

  typedef enum logic [1:0] {
    MD_PRESC  = 2'd0,
    MD_WIDE   = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmr_mode_e;

  // bit 3 gate, bit 2 counter select, bits 1:0 mode
  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [TMR_AW-1:0] A_MODE = 3'd0;
  localparam logic [TMR_AW-1:0] A_CTRL = 3'd1;
  localparam logic [TMR_AW-1:0] A_LO0  = 3'd2;
  localparam logic [TMR_AW-1:0] A_HI0  = 3'd3;
  localparam logic [TMR_AW-1:0] A_LO1  = 3'd4;
  localparam logic [TMR_AW-1:0] A_HI1  = 3'd5;

  localparam int unsigned RUN_BIT0 = 0;
  localparam int unsigned OVF_BIT0 = 4;

  typedef struct packed {
    logic [TMR_W-1:0] lo;
    logic [TMR_W-1:0] hi;
    logic             ovf;
  } step_t;

  // one count step of a non-split timer
  function automatic step_t f_step(tmr_mode_e md, logic [TMR_W-1:0] lo,
                                   logic [TMR_W-1:0] hi);
    step_t            r;
    logic [TMR_W-1:0] pmask;
    logic             wrap;
    pmask = TMR_W'((1 << TMR_PRE_W) - 1);
    r.lo  = lo;
    r.hi  = hi;
    r.ovf = 1'b0;
    wrap  = 1'b0;
    case (md)
      MD_PRESC: begin
        wrap = ((lo & pmask) == pmask);
        r.lo = (lo & ~pmask) | ((lo + 1'b1) & pmask);
        if (wrap) begin
          r.hi  = hi + 1'b1;
          r.ovf = (hi == '1);
        end
      end
      MD_WIDE: begin
        wrap = (lo == '1);
        r.lo = lo + 1'b1;
        if (wrap) begin
          r.hi  = hi + 1'b1;
          r.ovf = (hi == '1);
        end
      end
      MD_RELOAD: begin
        wrap  = (lo == '1);
        r.lo  = wrap ? hi : lo + 1'b1;
        r.ovf = wrap;
      end
      default: r = r;
    endcase
    return r;
  endfunction

  // carry and sum of a byte increment
  function automatic logic [TMR_W:0] f_byte_inc(logic [TMR_W-1:0] b);
    return {1'b0, b} + 1'b1;
  endfunction
endpackage

// File: rtl/twin_tmr_regs.sv
`timescale 1ns/1ps
module twin_tmr_regs
  import twin_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TMR_AW-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  input  logic [1:0]        set_ovf,
  input  logic [1:0]        clr_ovf,
  output logic [TMR_W-1:0]  mode_q,
  output logic [1:0]        run_q,
  output logic [1:0]        ovf_q
);
  logic mode_wr, ctrl_wr;
  assign mode_wr = wr_en && (wr_addr == A_MODE);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data;
  end

  for (genvar i = 0; i < 2; i++) begin : g_bits
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q[i] <= 1'b0;
        ovf_q[i] <= 1'b0;
      end else if (ctrl_wr) begin
        run_q[i] <= wr_data[RUN_BIT0 + i];
        ovf_q[i] <= wr_data[OVF_BIT0 + i];
      end else begin
        ovf_q[i] <= set_ovf[i] | (ovf_q[i] & ~clr_ovf[i]);
      end
    end

    // R10: an overflow beats a same-cycle clear strobe
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ovf[i] && !ctrl_wr) |=> ovf_q[i]);
    // R10: a lone strobe clears the flag
    a_r10_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ovf[i] && !set_ovf[i] && !ctrl_wr) |=> !ovf_q[i]);
  end
endmodule

// File: rtl/twin_tmr_chan.sv
`timescale 1ns/1ps
module twin_tmr_chan
  import twin_tmr_pkg::*;
#(
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             adv,
  input  logic             adv_hi,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] lo_q,
  output logic [TMR_W-1:0] hi_q,
  output logic             ovf_evt,
  output logic             hi_evt
);
  logic             split_on;
  step_t            st;
  logic [TMR_W:0]   lo_inc, hi_inc;
  logic [TMR_W-1:0] lo_d, hi_d;

  if (HAS_SPLIT) begin : g_split
    assign split_on = (mode == MD_SPLIT);
  end else begin : g_nosplit
    assign split_on = 1'b0;
  end

  always_comb begin
    st     = f_step(mode, lo_q, hi_q);
    lo_inc = f_byte_inc(lo_q);
    hi_inc = f_byte_inc(hi_q);
  end

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    ovf_evt = 1'b0;
    hi_evt  = 1'b0;
    if (split_on) begin
      if (adv) begin
        lo_d    = lo_inc[TMR_W-1:0];
        ovf_evt = lo_inc[TMR_W];
      end
      if (adv_hi) begin
        hi_d   = hi_inc[TMR_W-1:0];
        hi_evt = hi_inc[TMR_W];
      end
    end else if (adv) begin
      lo_d    = st.lo;
      hi_d    = st.hi;
      ovf_evt = st.ovf;
    end
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R2: nothing moves without an enable or a write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !adv_hi && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  // R3: prescaled mode keeps the upper low-byte bits
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PRESC && !wr_lo) |=>
      (lo_q[TMR_W-1:TMR_PRE_W] == $past(lo_q[TMR_W-1:TMR_PRE_W])));
  // R4: low-byte wrap carries into the high byte
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WIDE && adv && lo_q == '1 && !wr_hi) |=>
      (hi_q == TMR_W'($past(hi_q) + 1'b1)));
  // R5: low-byte wrap reloads from the high byte
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD && adv && lo_q == '1 && !wr_lo) |=> (lo_q == $past(hi_q)));
  // R9: a write wins over a count
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wr_data)));
endmodule

// File: rtl/twin_tmr.sv
`timescale 1ns/1ps
module twin_tmr
  import twin_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [TMR_AW-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  input  logic [TMR_AW-1:0] rd_addr,
  output logic [TMR_W-1:0]  rd_data,
  input  logic [1:0]        clr_ovf,
  output logic [1:0]        ovf
);
  logic [TMR_W-1:0] mode_q;
  logic [1:0]       run_q, ovf_q, set_ovf;
  logic [1:0]       adv, adv_hi, ovf_evt, hi_evt, wr_lo, wr_hi;
  logic [TMR_W-1:0] lo_q [2];
  logic [TMR_W-1:0] hi_q [2];
  tmr_cfg_t         cfg [2];
  logic             t0_split, ctrl_wr;
  logic [TMR_W-1:0] ctrl_view;

  twin_tmr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_ovf (set_ovf),
    .clr_ovf (clr_ovf),
    .mode_q  (mode_q),
    .run_q   (run_q),
    .ovf_q   (ovf_q)
  );

  assign t0_split = (cfg[0].mode == MD_SPLIT);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    localparam logic [TMR_AW-1:0] LO_A = TMR_AW'(A_LO0 + 2 * i);
    localparam logic [TMR_AW-1:0] HI_A = TMR_AW'(A_HI0 + 2 * i);
    logic stop_mode;

    assign cfg[i]   = tmr_cfg_t'(mode_q[CFG_W*i +: CFG_W]);
    assign wr_lo[i] = wr_en && (wr_addr == LO_A);
    assign wr_hi[i] = wr_en && (wr_addr == HI_A);

    if (i == 0) begin : g_t0
      assign stop_mode = 1'b0;
      assign adv_hi[i] = tick && run_q[1] && t0_split;
    end else begin : g_t1
      assign stop_mode = (cfg[i].mode == MD_SPLIT);
      assign adv_hi[i] = 1'b0;
    end

    assign adv[i] = tick && run_q[i] && !cfg[i].gate && !cfg[i].ext && !stop_mode;

    twin_tmr_chan #(.HAS_SPLIT(i == 0)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (cfg[i].mode),
      .adv     (adv[i]),
      .adv_hi  (adv_hi[i]),
      .wr_lo   (wr_lo[i]),
      .wr_hi   (wr_hi[i]),
      .wr_data (wr_data),
      .lo_q    (lo_q[i]),
      .hi_q    (hi_q[i]),
      .ovf_evt (ovf_evt[i]),
      .hi_evt  (hi_evt[i])
    );
  end

  // flag routing: split mode hands flag 1 to timer 0's high byte
  assign set_ovf[0] = ovf_evt[0];
  assign set_ovf[1] = t0_split ? hi_evt[0] : ovf_evt[1];

  always_comb begin
    ctrl_view = '0;
    for (int i = 0; i < 2; i++) begin
      ctrl_view[RUN_BIT0 + i] = run_q[i];
      ctrl_view[OVF_BIT0 + i] = ovf_q[i];
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_CTRL:  rd_data = ctrl_view;
      A_LO0:   rd_data = lo_q[0];
      A_HI0:   rd_data = hi_q[0];
      A_LO1:   rd_data = lo_q[1];
      A_HI1:   rd_data = hi_q[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf = ovf_q;

  // R7: in split mode only timer 0's high byte may raise flag 1
  a_r7_t1_flag_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && !hi_evt[0] && !ctrl_wr && !ovf_q[1]) |=> !ovf_q[1]);
  // R8: timer 1 in mode 3 is frozen
  a_r8_t1_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1].mode == MD_SPLIT && !wr_lo[1] && !wr_hi[1]) |=>
      ($stable(lo_q[1]) && $stable(hi_q[1])));
  // R6: split low byte and high byte never share an enable source
  a_r6_split_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && !run_q[1]) |-> !adv_hi[0]);
endmodule

// File: tb/twin_tmr_bench.sv
`timescale 1ns/1ps
module twin_tmr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] clr_ovf = '0;
  logic [1:0] ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_tmr u_twin_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr_ovf(clr_ovf), .ovf(ovf)
  );

  typedef struct packed {
    logic [7:0] md, ctl, l0, h0, l1, h1, n, el0, eh0, el1, eh1, ectl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h11, 8'h03, 8'hFE, 8'hFF, 8'h10, 8'h20, 8'd3, 8'h01, 8'h00, 8'h13, 8'h20, 8'h13},
    '{8'h00, 8'h01, 8'hFE, 8'hFF, 8'h05, 8'h06, 8'd2, 8'hE0, 8'h00, 8'h05, 8'h06, 8'h11},
    '{8'h22, 8'h03, 8'hFE, 8'h80, 8'hFF, 8'h7F, 8'd3, 8'h81, 8'h80, 8'h81, 8'h7F, 8'h33},
    '{8'h49, 8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'd5, 8'h11, 8'h22, 8'h33, 8'h44, 8'h03},
    '{8'h11, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'd4, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00},
    '{8'h13, 8'h03, 8'hFE, 8'h10, 8'hFF, 8'hFF, 8'd3, 8'h01, 8'h13, 8'h02, 8'h00, 8'h13},
    '{8'h33, 8'h02, 8'h50, 8'hFF, 8'hAA, 8'hBB, 8'd2, 8'h50, 8'h01, 8'hAA, 8'hBB, 8'h22},
    '{8'h30, 8'h02, 8'h01, 8'h02, 8'h03, 8'h04, 8'd4, 8'h01, 8'h02, 8'h03, 8'h04, 8'h02},
    '{8'h10, 8'h02, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h22}
  };
  localparam string VTAG [NV] = '{"R4", "R3", "R5", "R2", "R2", "R7", "R6", "R8", "R4"};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1", v, 8'h00);
    end
    check("R1 ovf", {6'd0, ovf}, 8'h00);
    // R11: configuration register reads back in place, unmapped reads 0
    wr(3'd0, 8'hA5);
    rd(3'd0, v); check("R11 cfg", v, 8'hA5);
    rd(3'd7, v); check("R11 unmapped", v, 8'h00);

    for (int k = 0; k < NV; k++) begin
      wr(3'd0, VECS[k].md);
      wr(3'd2, VECS[k].l0);
      wr(3'd3, VECS[k].h0);
      wr(3'd4, VECS[k].l1);
      wr(3'd5, VECS[k].h1);
      wr(3'd1, VECS[k].ctl);
      run_ticks(int'(VECS[k].n));
      rd(3'd2, v); check(VTAG[k], v, VECS[k].el0);
      rd(3'd3, v); check(VTAG[k], v, VECS[k].eh0);
      rd(3'd4, v); check(VTAG[k], v, VECS[k].el1);
      rd(3'd5, v); check(VTAG[k], v, VECS[k].eh1);
      rd(3'd1, v); check(VTAG[k], v, VECS[k].ectl);
    end

    // R9: write and count in one cycle
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h10);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h40;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); check("R9", v, 8'h40);
    run_ticks(1);
    rd(3'd2, v); check("R9 next", v, 8'h41);

    // R10: strobe clears a set flag, run bit untouched
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    run_ticks(1);
    check("R10 set", {6'd0, ovf}, 8'h01);
    @(negedge clk); clr_ovf = 2'b01;
    @(negedge clk); clr_ovf = 2'b00;
    check("R10 strobe", {6'd0, ovf}, 8'h00);
    rd(3'd1, v); check("R10 run kept", v, 8'h01);

    // R10: overflow and strobe together leave the flag set
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    @(negedge clk); tick = 1'b1; clr_ovf = 2'b01;
    @(negedge clk); tick = 1'b0; clr_ovf = 2'b00;
    check("R10 race", {6'd0, ovf}, 8'h01);

    // R10: writing 0 to the control flag bit clears it
    wr(3'd1, 8'h00);
    check("R10 write0", {6'd0, ovf}, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule